// File: doc/BRIEF.md
# Eight-Function Arithmetic/Logic Unit with Carry and Overflow

This block is a purely combinational datapath element. It takes two operands of a configurable width and a 3-bit operation code, and it produces a result of the same width together with a carry flag and a signed-overflow flag. Four of the codes are arithmetic: add, add with an extra one, subtract with an extra one taken off, and subtract. The other four are bitwise: AND, OR, NOR and XOR. All four arithmetic codes share one ripple adder. The low code bit feeds that adder's carry-in. The middle code bit inverts every bit of the second operand before it reaches the adder.

A bank of four bitwise results is steered by the two low code bits. The top code bit then picks either the adder sum or the bitwise result. The carry and overflow flags always come from the adder, whichever half drives the result. A surrounding datapath reads them only when an arithmetic code is active.

Top module: `arith_logic_unit`

## Requirements
- R1: With op code 000 the result is (A + B) modulo 2^W.
- R2: With op code 001 the result is (A + B + 1) modulo 2^W.
- R3: With op code 010 the result is (A − B − 1) modulo 2^W.
- R4: With op code 011 the result is (A − B) modulo 2^W.
- R5: With op code 100 the result is the bitwise AND of A and B.
- R6: With op code 101 the result is the bitwise OR of A and B.
- R7: With op code 110 the result is the bitwise NOR of A and B.
- R8: With op code 111 the result is the bitwise XOR of A and B.
- R9: For arithmetic codes (op bit 2 = 0), carry_out is bit W of the (W+1)-bit sum A + (B XOR {W{op[1]}}) + op[0].
- R10: For arithmetic codes, ovf is 1 exactly when the two adder operands A and (B XOR {W{op[1]}}) have equal sign bits and the sign bit of the sum differs from them.
- R11: For logic codes (op bit 2 = 1), carry_out and ovf take the values R9 and R10 give for the adder computation with the same op bits 1 and 0.
- R12: The outputs depend only on the present inputs: a new operand or op code takes effect with no clock edge and no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | W | First operand |
| opnd_b | input | W | Second operand |
| op_code | input | 3 | Operation select |
| result | output | W | Operation result |
| carry_out | output | 1 | Carry out of the adder's top bit |
| ovf | output | 1 | Signed overflow of the adder |

## Verification
The bench builds the unit with W = 8. At this width the operand extremes can be applied exhaustively against every op code: zero, one, all ones and the most-negative value. Random operand pairs are added on top of these. Eight bits are enough for the ripple carry to cross every stage. The sign bit is also shared with the carry chain, so both flags can be exercised by subtraction wrap-around and by add overflow at the most-negative and most-positive values.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD    = 3'b000,
        OP_ADDINC = 3'b001,
        OP_SUBDEC = 3'b010,
        OP_SUB    = 3'b011,
        OP_AND    = 3'b100,
        OP_OR     = 3'b101,
        OP_NOR    = 3'b110,
        OP_XOR    = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        LSEL_AND = 2'b00,
        LSEL_OR  = 2'b01,
        LSEL_NOR = 2'b10,
        LSEL_XOR = 2'b11
    } logic_sel_e;

    typedef struct packed {
        logic       is_logic;
        logic       invert_b;
        logic       carry_in;
        logic_sel_e lsel;
    } op_ctrl_t;

    function automatic op_ctrl_t decode_op(input logic [2:0] code);
        op_ctrl_t c;
        c.is_logic = code[2];
        c.invert_b = code[1];
        c.carry_in = code[0];
        c.lsel     = logic_sel_e'(code[1:0]);
        return c;
    endfunction

endpackage

// File: rtl/alu_operand_cond.sv
module alu_operand_cond #(
    parameter int W = 8
) (
    input  logic [W-1:0] b_in,
    input  logic         invert,
    output logic [W-1:0] b_out
);
    for (genvar i = 0; i < W; i++) begin : g_xor
        assign b_out[i] = b_in[i] ^ invert;
    end
endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         c_top,
    output logic         c_below
);
    logic [W:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_fa
        assign sum[i]      = x[i] ^ y[i] ^ chain[i];
        assign chain[i+1]  = (x[i] & y[i]) | (chain[i] & (x[i] ^ y[i]));
    end

    assign c_top   = chain[W];
    assign c_below = chain[W-1];
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_sel_e   sel,
    output logic [W-1:0] y
);
    logic [W-1:0] bank [4];

    assign bank[LSEL_AND] = a & b;
    assign bank[LSEL_OR]  = a | b;
    assign bank[LSEL_NOR] = ~(a | b);
    assign bank[LSEL_XOR] = a ^ b;

    always_comb begin
        y = bank[sel];
    end
endmodule

// File: rtl/arith_logic_unit.sv
module arith_logic_unit
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [2:0]   op_code,
    output logic [W-1:0] result,
    output logic         carry_out,
    output logic         ovf
);
    op_ctrl_t     ctrl;
    logic [W-1:0] b_cond;
    logic [W-1:0] add_sum;
    logic [W-1:0] log_res;
    logic         c_top;
    logic         c_below;

    assign ctrl = decode_op(op_code);

    alu_operand_cond #(.W(W)) u_bcond (
        .b_in   (opnd_b),
        .invert (ctrl.invert_b),
        .b_out  (b_cond)
    );

    alu_ripple_adder #(.W(W)) u_adder (
        .x       (opnd_a),
        .y       (b_cond),
        .cin     (ctrl.carry_in),
        .sum     (add_sum),
        .c_top   (c_top),
        .c_below (c_below)
    );

    alu_logic_unit #(.W(W)) u_logic (
        .a   (opnd_a),
        .b   (opnd_b),
        .sel (ctrl.lsel),
        .y   (log_res)
    );

    always_comb begin
        result = ctrl.is_logic ? log_res : add_sum;
    end

    assign carry_out = c_top;
    assign ovf       = c_top ^ c_below;
endmodule

// File: rtl/alu_checker.sv
module alu_checker #(
    parameter int W = 8
) (
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic [2:0]   op,
    input logic [W-1:0] r,
    input logic         c,
    input logic         v,
    input logic [W-1:0] sum_int
);
    logic [W-1:0] y_eff;
    logic [W:0]   wide;

    always_comb begin
        y_eff = op[1] ? ~b : b;
        wide  = {1'b0, a} + {1'b0, y_eff} + {{W{1'b0}}, op[0]};

        // R9
        carry_chk: assert (c == wide[W]);
        // R10
        ovf_chk: assert (v == ((a[W-1] == y_eff[W-1]) && (sum_int[W-1] != a[W-1])));
        // R1
        arith_pass_chk: assert (op[2] || (r == wide[W-1:0]));
        // R5
        and_chk: assert (op != 3'b100 || r == (a & b));
        // R7
        nor_chk: assert (op != 3'b110 || r == ~(a | b));
        // R8
        xor_chk: assert (op != 3'b111 || r == (a ^ b));
    end
endmodule

bind arith_logic_unit alu_checker #(.W(W)) u_chk (
    .a       (opnd_a),
    .b       (opnd_b),
    .op      (op_code),
    .r       (result),
    .c       (carry_out),
    .v       (ovf),
    .sum_int (add_sum)
);

// File: tb/arith_logic_unit_test.sv
module arith_logic_unit_test;
    localparam int W = 8;
    localparam logic [W-1:0] MAXV = {W{1'b1}};
    localparam logic [W-1:0] MNEG = {1'b1, {(W-1){1'b0}}};

    logic         clk = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [2:0]   op = 3'b000;
    logic [W-1:0] result;
    logic         carry_out;
    logic         ovf;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    arith_logic_unit #(.W(W)) uut (
        .opnd_a   (a),
        .opnd_b   (b),
        .op_code  (op),
        .result   (result),
        .carry_out(carry_out),
        .ovf      (ovf)
    );

    function automatic logic [W:0] adder_model(input logic [W-1:0] x, input logic [W-1:0] y, input logic [2:0] f);
        logic [W-1:0] yy;
        yy = f[1] ? ~y : y;
        return {1'b0, x} + {1'b0, yy} + {{W{1'b0}}, f[0]};
    endfunction

    function automatic logic ovf_model(input logic [W-1:0] x, input logic [W-1:0] y, input logic [2:0] f);
        logic [W-1:0] yy;
        logic [W:0]   s;
        yy = f[1] ? ~y : y;
        s  = adder_model(x, y, f);
        return (x[W-1] == yy[W-1]) && (s[W-1] != x[W-1]);
    endfunction

    function automatic logic [W-1:0] result_model(input logic [W-1:0] x, input logic [W-1:0] y, input logic [2:0] f);
        case (f)
            3'b000: return x + y;
            3'b001: return x + y + 1'b1;
            3'b010: return x - y - 1'b1;
            3'b011: return x - y;
            3'b100: return x & y;
            3'b101: return x | y;
            3'b110: return ~(x | y);
            default: return x ^ y;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] f);
        case (f)
            3'b000: return "R1";
            3'b001: return "R2";
            3'b010: return "R3";
            3'b011: return "R4";
            3'b100: return "R5";
            3'b101: return "R6";
            3'b110: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h op=%b actual=%h expected=%h", tag, a, b, op, act, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic [2:0] f);
        logic [W:0] s;
        @(negedge clk);
        a  = x;
        b  = y;
        op = f;
        @(posedge clk);
        #1;
        s = adder_model(x, y, f);
        check(tag_of(f), result, result_model(x, y, f));
        if (!f[2]) begin
            check("R9", W'(carry_out), W'(s[W]));
            check("R10", W'(ovf), W'(ovf_model(x, y, f)));
        end else begin
            check("R11", W'({carry_out, ovf}), W'({s[W], ovf_model(x, y, f)}));
        end
    endtask

    initial begin
        logic [W-1:0] corners [4];
        corners[0] = '0;
        corners[1] = {{(W-1){1'b0}}, 1'b1};
        corners[2] = MAXV;
        corners[3] = MNEG;
        void'($urandom(32'h5EED));

        #1;
        // R12: zero inputs settle with no clock edge
        check("R12", result, '0);
        check("R12", W'({carry_out, ovf}), '0);
        a = 8'h35; b = 8'h0C; op = 3'b011;
        #1;
        // R12: new inputs take effect immediately
        check("R12", result, 8'h29);

        for (int f = 0; f < 8; f++)
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++)
                    apply(corners[i], corners[j], 3'(f));

        // R10 directed: positive overflow on add, negative wrap on subtract
        apply(8'h7F, 8'h01, 3'b000);
        apply(MNEG, 8'h01, 3'b011);

        for (int k = 0; k < 600; k++)
            apply(W'($urandom), W'($urandom), 3'($urandom));

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule